// File: doc/BRIEF.md
# Radix-2 Booth Sequential Signed Multiplier

This block multiplies a signed multiplicand of `MCAND_W` bits by a signed multiplier of `MPLIER_W` bits over several clock cycles. It produces a signed product of `MCAND_W + MPLIER_W` bits. Each cycle it looks at the two lowest bits of a running product register and recodes them into one of three actions: add the multiplicand, subtract it, or do nothing. The register then shifts right by one place, with the sign bit copied into the top. The register carries one spare guard bit at the top. Because of this bit, the most negative multiplicand needs no special case.

Operands enter on a valid/ready handshake. The block accepts a pair only when idle. `in_ready` then stays low until the result has been handed over. The result leaves on a second valid/ready handshake. While `out_valid` is high and `out_ready` is low, the result is held unchanged. A completed transfer returns the block to idle. `done` is a plain status pulse marking the cycle in which the result first appears. `product_o` keeps its last value until the next operand pair is accepted.

Top module: `booth_mult`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0, `done` is 0 and `product_o` is 0.
- R2: For every pair of operands, `product_o` equals the two's complement product of `mcand_i` and `mplier_i`, both taken as signed.
- R3: A multiplicand equal to the most negative value gives the correct product, with no overflow. Examples: -8 × 2 = -16 (8'b11110000) and -8 × -8 = +64 with 4-bit operands.
- R4: `out_valid` rises exactly `MPLIER_W` clock cycles after the cycle in which an operand pair is accepted (`in_valid` and `in_ready` both high).
- R5: `done` is high for exactly one cycle, and that cycle is the first cycle in which `out_valid` is high.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `product_o` does not change.
- R7: From acceptance until the result has been taken, `in_ready` is 0. Any `in_valid` or operand activity in that period has no effect on the result.
- R8: Once the result has been taken (`out_valid` and `out_ready` both high), the block returns to `in_ready` = 1. `product_o` keeps its value until the next pair is accepted.
- R9: With 4-bit operands, 3 × -4 gives 8'b11110100 (-12).
- R10: A zero multiplier gives 0. A multiplier of -1 gives the negated multiplicand. A multiplier of alternating bits gives the correct product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair is offered |
| in_ready | output | 1 | Block is idle and can accept a pair |
| mcand_i | input | MCAND_W | Signed multiplicand |
| mplier_i | input | MPLIER_W | Signed multiplier |
| out_valid | output | 1 | Product is available |
| out_ready | input | 1 | Consumer takes the product |
| done | output | 1 | One-cycle pulse when the product first appears |
| product_o | output | MCAND_W+MPLIER_W | Signed product |

## Verification
A wrong recoding decision or a lost guard bit corrupts the upper field of the running register. That error is not visible while the block runs. It shows up only as a wrong `product_o` when `out_valid` rises, `MPLIER_W` cycles after acceptance. Because of this, every operand pair of a 4×4 configuration is compared against the arithmetic product. A miscounted iteration shows up as `out_valid` arriving one cycle early or late. A broken handshake shows up within one cycle, as `in_ready` high during a run or as `product_o` moving while the result is held.

// File: rtl/booth_mult_pkg.sv
package booth_mult_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } ctrl_state_e;

  typedef enum logic [1:0] {
    OP_SKIP = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2
  } booth_op_e;

  // Bit pair {current, previous}: 01 -> add, 10 -> subtract, else skip.
  function automatic booth_op_e decode_pair(input logic [1:0] pair);
    booth_op_e op;
    case (pair)
      2'b01:   op = OP_ADD;
      2'b10:   op = OP_SUB;
      default: op = OP_SKIP;
    endcase
    return op;
  endfunction

endpackage

// File: rtl/booth_recode.sv
module booth_recode
  import booth_mult_pkg::*;
(
  input  logic [1:0] pair_i,
  output logic       add_o,
  output logic       sub_o
);
  booth_op_e op;

  always_comb begin
    op    = decode_pair(pair_i);
    add_o = (op == OP_ADD);
    sub_o = (op == OP_SUB);
  end
endmodule

// File: rtl/booth_step.sv
module booth_step #(
  parameter int HI_W = 5,
  parameter int LO_W = 5
) (
  input  logic [HI_W+LO_W-1:0] p_i,
  input  logic [HI_W-1:0]      add_hi_i,
  input  logic [HI_W-1:0]      sub_hi_i,
  output logic [HI_W+LO_W-1:0] p_o
);
  localparam int W = HI_W + LO_W;

  logic            add_en, sub_en;
  logic [HI_W-1:0] upper, addend, sum;
  logic [LO_W-1:0] lower;

  booth_recode u_recode (
    .pair_i (p_i[1:0]),
    .add_o  (add_en),
    .sub_o  (sub_en)
  );

  always_comb begin
    upper = p_i[W-1 -: HI_W];
    lower = p_i[LO_W-1:0];
    if (add_en)      addend = add_hi_i;
    else if (sub_en) addend = sub_hi_i;
    else             addend = '0;
    sum = upper + addend;                 // carry out discarded
    p_o = {sum[HI_W-1], sum, lower[LO_W-1:1]};  // arithmetic shift right
  end
endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl
  import booth_mult_pkg::*;
#(
  parameter int ITER = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic out_ready,
  output logic in_ready,
  output logic load_o,
  output logic step_o,
  output logic out_valid,
  output logic done
);
  localparam int CNT_W = (ITER < 2) ? 1 : $clog2(ITER + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ITER - 1);

  ctrl_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic             last_step;

  assign in_ready  = (state_q == ST_IDLE);
  assign out_valid = (state_q == ST_HOLD);
  assign load_o    = in_ready && in_valid;
  assign step_o    = (state_q == ST_RUN);
  assign last_step = step_o && (cnt_q == LAST);
  assign done      = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= last_step;
      case (state_q)
        ST_IDLE: if (in_valid) begin
          state_q <= ST_RUN;
          cnt_q   <= '0;
        end
        ST_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) state_q <= ST_HOLD;
        end
        ST_HOLD: if (out_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r4_last_step_to_valid: assert property (@(posedge clk) disable iff (!rst_n)
    last_step |=> out_valid);
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r5_done_with_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> done);
  a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> !in_ready);
endmodule

// File: rtl/booth_mult.sv
module booth_mult
  import booth_mult_pkg::*;
#(
  parameter int MCAND_W  = 16,
  parameter int MPLIER_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [MCAND_W-1:0]          mcand_i,
  input  logic [MPLIER_W-1:0]         mplier_i,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic                        done,
  output logic [MCAND_W+MPLIER_W-1:0] product_o
);
  localparam int HI_W = MCAND_W + 1;   // multiplicand plus guard bit
  localparam int LO_W = MPLIER_W + 1;  // multiplier plus appended bit
  localparam int W    = HI_W + LO_W;

  logic            load, step;
  logic [W-1:0]    p_q, p_next;
  logic [HI_W-1:0] add_hi_q, sub_hi_q, mcand_ext;

  booth_ctrl #(.ITER(MPLIER_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .load_o    (load),
    .step_o    (step),
    .out_valid (out_valid),
    .done      (done)
  );

  booth_step #(.HI_W(HI_W), .LO_W(LO_W)) u_step (
    .p_i      (p_q),
    .add_hi_i (add_hi_q),
    .sub_hi_i (sub_hi_q),
    .p_o      (p_next)
  );

  assign mcand_ext = {mcand_i[MCAND_W-1], mcand_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_q      <= '0;
      add_hi_q <= '0;
      sub_hi_q <= '0;
    end else if (load) begin
      p_q      <= {{HI_W{1'b0}}, mplier_i, 1'b0};
      add_hi_q <= mcand_ext;
      sub_hi_q <= -mcand_ext;
    end else if (step) begin
      p_q <= p_next;
    end
  end

  assign product_o = p_q[W-2:1];

  a_r6_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);
  a_r6_hold_product: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(product_o));
  a_r8_idle_product: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> $stable(product_o));
  a_r7_no_ready_while_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
endmodule

// File: tb/tb_booth_mult.sv
module tb_booth_mult;
  localparam int MW = 4;
  localparam int RW = 4;
  localparam int PW = MW + RW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [MW-1:0] mcand = '0;
  logic [RW-1:0] mplier = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic          done;
  logic [PW-1:0] product;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;  // 50 MHz

  booth_mult #(.MCAND_W(MW), .MPLIER_W(RW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .mcand_i(mcand), .mplier_i(mplier), .out_valid(out_valid),
    .out_ready(out_ready), .done(done), .product_o(product)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] ref_mul(input logic [MW-1:0] m, input logic [RW-1:0] r);
    int sm = m[MW-1] ? int'(m) - (1 << MW) : int'(m);
    int sr = r[RW-1] ? int'(r) - (1 << RW) : int'(r);
    int pr = sm * sr;
    return pr[PW-1:0];
  endfunction

  // One full transaction; checks R4..R8 on every call, product under tag.
  task automatic run_op(input logic [MW-1:0] m, input logic [RW-1:0] r,
                        input int hold, input string tag);
    logic [PW-1:0] exp = ref_mul(m, r);
    logic [PW-1:0] got;
    int k;
    @(negedge clk);
    mcand = m; mplier = r; in_valid = 1'b1; out_ready = 1'b0;
    check("R7 idle ready", in_ready, 1);
    @(posedge clk);
    @(negedge clk);
    mcand = ~m; mplier = ~r;  // R7: keep offering junk during the run
    k = 1;
    while (!out_valid && k < 4 * RW) begin
      if (in_ready) check("R7 busy ready", in_ready, 0);
      @(posedge clk); @(negedge clk);
      if (!out_valid) k++;
    end
    check("R4 latency", k, RW);
    check("R5 done pulse", done, 1);
    check(tag, product, exp);
    got = product;
    for (int h = 0; h < hold; h++) begin
      @(posedge clk); @(negedge clk);
      check("R5 done single", done, 0);
      check("R6 valid held", out_valid, 1);
      check("R6 product held", product, got);
      check("R7 ready low in hold", in_ready, 0);
    end
    in_valid = 1'b0; out_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    out_ready = 1'b0;
    check("R8 back to idle", {in_ready, out_valid}, 2'b10);
    @(posedge clk); @(negedge clk);
    check("R8 product kept", product, exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 in_ready", in_ready, 1);
    check("R1 out_valid", out_valid, 0);
    check("R1 done", done, 0);
    check("R1 product", product, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {in_ready, out_valid, done}, 3'b100);

    run_op(4'd3, 4'b1100, 1, "R9 3x-4");
    check("R9 pattern", product, 8'b11110100);
    run_op(4'b1000, 4'd2, 2, "R3 -8x2");
    check("R3 pattern", product, 8'b11110000);
    run_op(4'b1000, 4'b1000, 0, "R3 -8x-8");
    check("R3 plus64", product, 8'd64);
    run_op(4'd7, 4'd0, 1, "R10 zero mult");
    run_op(4'd5, 4'b1111, 0, "R10 minus one");
    run_op(4'b1001, 4'b0101, 3, "R10 alternating");
    run_op(4'd6, 4'b1010, 0, "R10 alternating neg");

    for (int mi = 0; mi < (1 << MW); mi++)
      for (int ri = 0; ri < (1 << RW); ri++)
        run_op(MW'(mi), RW'(ri), (mi + ri) % 3, "R2 sweep");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule